// File: doc/BRIEF.md
# Pin Interrupt Trigger Detector

This block keeps the interrupt-related fields of a single pin's control word and turns the pin's already-filtered input level into interrupt and wake status. Software configures the block through a 32-bit word. The configuration selects edge or level detection, which polarity counts as an event, a separate enable and an unmask, and one wake enable for each sleep state. The block records an interrupt-status bit and a wake-status bit. It raises a pending line toward a chip-level interrupt aggregator. Software acknowledges a pin by writing back the word it has just read, because the status bits are write-one-to-clear.

Events are found by comparing the current input level with the level seen on the previous clock. In level mode, the active level re-arms the status on every cycle that the level is present. The mask only gates the pending line. Status is still recorded while the pin is masked, so software can poll a masked pin. A wake event is recorded when the current sleep state has its wake enable set. This does not depend on the interrupt enable.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset, every configuration and status bit reads 0, `int_status`, `wake_status` and `pending` are 0, and only bit 10 of `rd_data` may be set (it follows the pin).
- R2: Word layout: bit 0 = level mode (1) / edge mode (0); bits 2:1 = sense; bit 3 = interrupt enable; bit 4 = unmask (1 = unmasked); bits 7:5 = wake enable for sleep states 1, 2, 3; bit 8 = interrupt status; bit 9 = wake status; bit 10 = pin level (read-only); bits 31:11 read 0. A write stores bits 7:0, which read back unchanged.
- R3: In edge mode, sense 01 records a rising edge, sense 00 records a falling edge, sense 10 records both, and sense 11 records nothing. The status appears on the clock edge that follows the input change. An edge of the opposite polarity sets nothing.
- R4: In level mode, sense 01 records while the pin is high, sense 00 records while it is low, and sense 1x records nothing. The status is set again on each cycle that the active level persists.
- R5: While the interrupt enable is 0, no event sets the interrupt status.
- R6: The interrupt status is recorded whether or not the pin is masked. `pending` = (interrupt status AND unmask) OR wake status.
- R7: Writing 1 to bit 8 or bit 9 clears that status bit, and writing 0 leaves it unchanged. Writing back the value just read acknowledges the pin.
- R8: When a clearing write and a new event fall on the same clock edge, the status stays set.
- R9: `sleep_state` 0 means awake, and values 1 to 3 select a sleep state. The wake status is set by an event only when `sleep_state` is non-zero and that state's wake enable bit is set. This does not depend on the interrupt enable.
- R10: Bit 10 of `rd_data` reflects `pin_level` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | 1 | Filtered pin level |
| sleep_state | input | 2 | Current power state, 0 = awake |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| int_status | output | 1 | Recorded interrupt status |
| wake_status | output | 1 | Recorded wake status |
| pending | output | 1 | Request toward the aggregator |

## Verification
The bench builds the block with its defaults: a 32-bit word and three wake states. This means every sleep state can be reached, including the one whose enable is left clear, alongside the awake state. It drives every sense code in both detection modes. It also lines a clearing write up exactly with a fresh edge and with a held active level, so that the rule that the event wins is observed at the ports. Masked and unmasked runs compare the recorded status with `pending`.

// File: rtl/pin_irq_detect.sv
`timescale 1ns/1ps
module pin_irq_detect #(
  parameter int DATA_W = 32,
  parameter int WAKE_N = 3,
  localparam int SS_W = $clog2(WAKE_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_level,
  input  logic [SS_W-1:0]   sleep_state,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              int_status,
  output logic              wake_status,
  output logic              pending
);
  localparam int B_LVL  = 0;
  localparam int B_SNS  = 1;
  localparam int B_IEN  = 3;
  localparam int B_UNM  = 4;
  localparam int B_WAKE = 5;
  localparam int B_IST  = B_WAKE + WAKE_N;
  localparam int B_WST  = B_IST + 1;
  localparam int B_PIN  = B_WST + 1;

  logic              lvl_mode;
  logic [1:0]        sense;
  logic              int_en;
  logic              unmask;
  logic [WAKE_N-1:0] wake_en;
  logic              prev_level, prev_valid;

  logic rise, fall, edge_hit, level_hit, ev_hit;
  logic set_int, set_wake, clr_int, clr_wake;
  logic [WAKE_N-1:0] wake_sel;

  assign rise = prev_valid & pin_level & ~prev_level;
  assign fall = prev_valid & ~pin_level & prev_level;

  always_comb begin
    case (sense)
      2'b00:   edge_hit = fall;
      2'b01:   edge_hit = rise;
      2'b10:   edge_hit = rise | fall;
      default: edge_hit = 1'b0;
    endcase
  end

  assign level_hit = (sense == 2'b01) ? pin_level :
                     (sense == 2'b00) ? ~pin_level : 1'b0;
  assign ev_hit = lvl_mode ? level_hit : edge_hit;

  for (genvar g = 0; g < WAKE_N; g++) begin : g_wake
    assign wake_sel[g] = wake_en[g] && (sleep_state == SS_W'(g + 1));
  end

  assign set_int  = ev_hit & int_en;
  assign set_wake = ev_hit & (|wake_sel);
  assign clr_int  = wr_en & wr_data[B_IST];
  assign clr_wake = wr_en & wr_data[B_WST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_mode    <= 1'b0;
      sense       <= 2'b00;
      int_en      <= 1'b0;
      unmask      <= 1'b0;
      wake_en     <= '0;
      int_status  <= 1'b0;
      wake_status <= 1'b0;
      prev_level  <= 1'b0;
      prev_valid  <= 1'b0;
    end else begin
      prev_level <= pin_level;
      prev_valid <= 1'b1;
      if (wr_en) begin
        lvl_mode <= wr_data[B_LVL];
        sense    <= wr_data[B_SNS +: 2];
        int_en   <= wr_data[B_IEN];
        unmask   <= wr_data[B_UNM];
        wake_en  <= wr_data[B_WAKE +: WAKE_N];
      end
      int_status  <= set_int  | (int_status  & ~clr_int);
      wake_status <= set_wake | (wake_status & ~clr_wake);
    end
  end

  assign pending = (int_status & unmask) | wake_status;

  always_comb begin
    rd_data = '0;
    rd_data[B_LVL]            = lvl_mode;
    rd_data[B_SNS +: 2]       = sense;
    rd_data[B_IEN]            = int_en;
    rd_data[B_UNM]            = unmask;
    rd_data[B_WAKE +: WAKE_N] = wake_en;
    rd_data[B_IST]            = int_status;
    rd_data[B_WST]            = wake_status;
    rd_data[B_PIN]            = pin_level;
  end

  assert_pend_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (int_status || wake_status));
  assert_mask_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!unmask && !wake_status) |-> !pending);
  assert_ien_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_status) |-> $past(int_en));
  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_int) && !$past(set_int)) |-> !int_status);
  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_int) |-> int_status);
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> ($stable(int_en) && $stable(sense) && $stable(wake_en)));
  assert_awake_nowake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_status) |-> ($past(sleep_state) != '0));
endmodule

// File: tb/tb_pin_irq_detect.sv
`timescale 1ns/1ps
module tb_pin_irq_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_level = 1'b0;
  logic [1:0]  sleep_state = 2'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        int_status, wake_status, pending;
  int total = 0;
  int bad = 0;

  localparam logic [31:0] IST = 32'h100;
  localparam logic [31:0] WST = 32'h200;

  always #2.5 clk = ~clk;

  pin_irq_detect dut (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .sleep_state(sleep_state),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .int_status(int_status), .wake_status(wake_status), .pending(pending)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pin(input logic v);
    @(negedge clk); pin_level = v;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    chk(rd_data == 32'h0, "R1 word", rd_data, 32'h0);
    chk({int_status, wake_status, pending} == 3'b000, "R1 outputs",
        {int_status, wake_status, pending}, 0);
  endtask

  task automatic t_layout;
    wr(32'hFFFF_FFFF);
    chk(rd_data == 32'h0000_00FF, "R2 all ones", rd_data, 32'hFF);
    wr(32'h0000_00A5);
    chk(rd_data == 32'h0000_00A5, "R2 pattern", rd_data, 32'hA5);
    wr(32'h0);
    chk(rd_data == 32'h0, "R2 zero", rd_data, 0);
    @(negedge clk); pin_level = 1'b1; #1;
    chk(rd_data[10] == 1'b1, "R10 pin high", rd_data, 32'h400);
    @(negedge clk); pin_level = 1'b0; #1;
    chk(rd_data[10] == 1'b0, "R10 pin low", rd_data, 0);
  endtask

  task automatic t_edges;
    wr(32'h1A);
    @(negedge clk); pin_level = 1'b1; #1;
    chk(int_status == 1'b0, "R3 not before edge", int_status, 0);
    @(posedge clk); #1;
    chk(int_status == 1'b1, "R3 rising", int_status, 1);
    chk(pending == 1'b1, "R6 unmasked pending", pending, 1);
    wr(rd_data);
    chk(int_status == 1'b0, "R7 readback ack", int_status, 0);
    pin(1'b0);
    chk(int_status == 1'b0, "R3 rising ignores fall", int_status, 0);
    wr(32'h18);
    pin(1'b1);
    chk(int_status == 1'b0, "R3 falling ignores rise", int_status, 0);
    pin(1'b0);
    chk(int_status == 1'b1, "R3 falling", int_status, 1);
    wr(32'h18);
    chk(int_status == 1'b1, "R7 zero keeps", int_status, 1);
    wr(32'h18 | IST);
    chk(int_status == 1'b0, "R7 clear", int_status, 0);
    wr(32'h1C);
    pin(1'b1);
    chk(int_status == 1'b1, "R3 both rise", int_status, 1);
    wr(32'h1C | IST);
    pin(1'b0);
    chk(int_status == 1'b1, "R3 both fall", int_status, 1);
    wr(32'h1E | IST);
    pin(1'b1);
    chk(int_status == 1'b0, "R3 code11 rise", int_status, 0);
    pin(1'b0);
    chk(int_status == 1'b0, "R3 code11 fall", int_status, 0);
  endtask

  task automatic t_disabled;
    wr(32'h12);
    pin(1'b1);
    chk(int_status == 1'b0, "R5 disabled rise", int_status, 0);
    pin(1'b0);
    chk(pending == 1'b0, "R5 disabled pending", pending, 0);
  endtask

  task automatic t_level;
    wr(32'h1B);
    chk(int_status == 1'b0, "R4 inactive", int_status, 0);
    pin(1'b1);
    chk(int_status == 1'b1, "R4 high", int_status, 1);
    wr(32'h1B | IST);
    chk(int_status == 1'b1, "R4 held rearm", int_status, 1);
    pin(1'b0);
    wr(32'h1B | IST);
    @(posedge clk); #1;
    chk(int_status == 1'b0, "R4 released", int_status, 0);
    wr(32'h19);
    chk(int_status == 1'b0, "R4 low arm delay", int_status, 0);
    @(posedge clk); #1;
    chk(int_status == 1'b1, "R4 low", int_status, 1);
    pin(1'b1);
    wr(32'h1D | IST);
    @(posedge clk); #1;
    chk(int_status == 1'b0, "R4 code1x", int_status, 0);
    pin(1'b0);
    @(posedge clk); #1;
    chk(int_status == 1'b0, "R4 code1x low", int_status, 0);
  endtask

  task automatic t_collide;
    wr(32'h1A | IST);
    @(negedge clk);
    pin_level = 1'b1; wr_en = 1'b1; wr_data = 32'h1A | IST;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = '0;
    chk(int_status == 1'b1, "R8 event wins", int_status, 1);
    wr(32'h1A | IST);
    chk(int_status == 1'b0, "R8 cleared later", int_status, 0);
    pin(1'b0);
  endtask

  task automatic t_mask;
    wr(32'h0A);
    pin(1'b1);
    chk(int_status == 1'b1, "R6 masked recorded", int_status, 1);
    chk(pending == 1'b0, "R6 masked no pending", pending, 0);
    wr(32'h1A);
    chk(pending == 1'b1, "R6 unmask pending", pending, 1);
    wr(32'h0A | IST);
    pin(1'b0);
  endtask

  task automatic t_wake;
    sleep_state = 2'd2;
    wr(32'h42);
    pin(1'b1);
    chk(wake_status == 1'b1, "R9 wake set", wake_status, 1);
    chk(int_status == 1'b0, "R9 int off", int_status, 0);
    chk(pending == 1'b1, "R9 wake pending", pending, 1);
    chk(rd_data[9] == 1'b1, "R9 wake bit", rd_data, WST);
    wr(32'h42 | WST);
    chk(wake_status == 1'b0, "R7 wake clear", wake_status, 0);
    pin(1'b0);
    sleep_state = 2'd0;
    pin(1'b1);
    chk(wake_status == 1'b0, "R9 awake", wake_status, 0);
    pin(1'b0);
    sleep_state = 2'd3;
    pin(1'b1);
    chk(wake_status == 1'b0, "R9 state3 off", wake_status, 0);
    pin(1'b0);
    sleep_state = 2'd1;
    pin(1'b1);
    chk(wake_status == 1'b0, "R9 state1 off", wake_status, 0);
    sleep_state = 2'd0;
    pin(1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_layout();
    t_edges();
    t_disabled();
    t_level();
    t_collide();
    t_mask();
    t_wake();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule